// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between a processor's memory port and a single-ported memory. Stores from the processor are parked in a small in-order queue and written to memory later, oldest first, whenever the memory port is free. Loads need not wait behind those parked stores. A load whose address matches a queued store takes its value from the newest such store and never reaches memory. A load that matches nothing goes straight to memory, ahead of any older stores that are waiting to drain.

The memory port is a single valid/ready request channel shared by reads and writes, with a write-enable bit. A read-response input returns the data for the one read that may be outstanding. An `empty_o` flag reports that no store is waiting, so that a later ordering unit can hold off until earlier stores are visible. The queue depth must be a power of two.

Top module: `sb_top`

## Requirements
- R1: After reset, `empty_o` and `st_ready_o` are high and neither `mem_req_valid_o` nor `ld_rsp_valid_o` is asserted.
- R2: A store is taken on a cycle where `st_valid_i` and `st_ready_o` are both high. `st_ready_o` is low exactly while DEPTH stores are queued.
- R3: Queued stores are written to memory strictly in the order they were accepted. A write is one cycle with `mem_req_valid_o`, `mem_req_ready_i` and `mem_req_we_o` high, and at most one store leaves per cycle. `mem_req_we_o` = 1 marks a write and 0 marks a read.
- R4: A load that matches no queued store drives a read (`mem_req_we_o` = 0, `mem_req_addr_o` = load address) in the cycle it is offered. It wins the port over a pending store write, and it is accepted only when `mem_req_ready_i` is high.
- R5: A load address is compared with every queued store. On a match the load is accepted without a memory read, and its data appears on `ld_rsp_data_o` with `ld_rsp_valid_o` high in the cycle after acceptance.
- R6: When several queued stores match a load, the returned data is that of the most recently accepted one.
- R7: A missed load returns `mem_rsp_data_i` in the cycle `mem_rsp_valid_i` is high. While it waits, `ld_ready_o` stays low, so only one read is ever outstanding.
- R8: A store and a load presented in the same cycle count as load first, so the load does not see that store's data.
- R9: `empty_o` is high exactly when no store is queued. While it is high, no write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store can be accepted |
| st_addr_i | input | AW | Store word address |
| st_data_i | input | DW | Store data |
| ld_valid_i | input | 1 | Load request valid |
| ld_ready_o | output | 1 | Load can be accepted |
| ld_addr_i | input | AW | Load word address |
| ld_rsp_valid_o | output | 1 | Load data valid |
| ld_rsp_data_o | output | DW | Load data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | AW | Memory address |
| mem_req_wdata_o | output | DW | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DW | Read data |
| empty_o | output | 1 | No store queued |

## Verification
On every cycle the assertions check the following: occupancy moves by exactly one on an accepted store or a drained store; an accepted missing load owns the port as a read at its own address; an accepted hit issues no read and answers in the next cycle; a miss closes the load port; and no write appears while the queue is empty. The bench's scenarios show the properties that depend on data and order. These are the youngest-match choice among duplicate addresses, drain order against a log of memory writes, the read overtaking older writes, the same-cycle store/load ordering, and the values that memory holds after a drain.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_LOAD  = 2'd1,
    PORT_STORE = 2'd2
  } port_owner_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CW   = PTRW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o,
  // entries in age order: index 0 oldest
  output logic          age_vld_o  [DEPTH],
  output logic [AW-1:0] age_addr_o [DEPTH],
  output logic [DW-1:0] age_data_o [DEPTH]
);
  logic [AW-1:0]   addr_q [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];
  logic [PTRW-1:0] head_q, tail_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end

  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign cnt_o       = cnt_q;
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [PTRW-1:0] slot;
    assign slot          = head_q + PTRW'(g);
    assign age_vld_o[g]  = (CW'(g) < cnt_q);
    assign age_addr_o[g] = addr_q[slot];
    assign age_data_o[g] = data_q[slot];
  end
endmodule

// File: rtl/sb_match.sv
module sb_match #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [AW-1:0] ld_addr_i,
  input  logic          age_vld_i  [DEPTH],
  input  logic [AW-1:0] age_addr_i [DEPTH],
  input  logic [DW-1:0] age_data_i [DEPTH],
  output logic          hit_o,
  output logic [DW-1:0] data_o
);
  // later (younger) slots overwrite earlier ones
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (age_vld_i[i] && age_addr_i[i] == ld_addr_i) begin
        hit_o  = 1'b1;
        data_o = age_data_i[i];
      end
    end
  end
endmodule

// File: rtl/sb_arb.sv
module sb_arb
  import sb_pkg::*;
(
  input  logic        ld_req_i,
  input  logic        st_req_i,
  input  logic        mem_ready_i,
  output port_owner_e owner_o,
  output logic        ld_gnt_o,
  output logic        st_gnt_o
);
  always_comb begin
    if (ld_req_i)      owner_o = PORT_LOAD;
    else if (st_req_i) owner_o = PORT_STORE;
    else               owner_o = PORT_IDLE;
  end

  assign ld_gnt_o = (owner_o == PORT_LOAD)  && mem_ready_i;
  assign st_gnt_o = (owner_o == PORT_STORE) && mem_ready_i;
endmodule

// File: rtl/sb_top.sv
module sb_top
  import sb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          ld_valid_i,
  output logic          ld_ready_o,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_rsp_valid_o,
  output logic [DW-1:0] ld_rsp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          empty_o
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int CW   = PTRW + 1;

  logic          q_push, q_pop, q_full, q_empty;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [CW-1:0] q_cnt;
  logic          age_vld  [DEPTH];
  logic [AW-1:0] age_addr [DEPTH];
  logic [DW-1:0] age_data [DEPTH];

  logic          ld_hit;
  logic [DW-1:0] hit_data;
  logic          ld_busy_q, fwd_valid_q;
  logic [DW-1:0] fwd_data_q;
  logic          ld_try, ld_miss_req, ld_acc;
  logic          ld_gnt, st_gnt;
  port_owner_e   owner;

  sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) queue_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (q_push),
    .push_addr_i (st_addr_i),
    .push_data_i (st_data_i),
    .pop_i       (q_pop),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .cnt_o       (q_cnt),
    .full_o      (q_full),
    .empty_o     (q_empty),
    .age_vld_o   (age_vld),
    .age_addr_o  (age_addr),
    .age_data_o  (age_data)
  );

  sb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) match_i (
    .ld_addr_i  (ld_addr_i),
    .age_vld_i  (age_vld),
    .age_addr_i (age_addr),
    .age_data_i (age_data),
    .hit_o      (ld_hit),
    .data_o     (hit_data)
  );

  assign ld_try      = ld_valid_i && !ld_busy_q;
  assign ld_miss_req = ld_try && !ld_hit;

  sb_arb arb_i (
    .ld_req_i    (ld_miss_req),
    .st_req_i    (!q_empty),
    .mem_ready_i (mem_req_ready_i),
    .owner_o     (owner),
    .ld_gnt_o    (ld_gnt),
    .st_gnt_o    (st_gnt)
  );

  // a hit never needs the port; a miss needs the grant
  assign ld_ready_o = !ld_busy_q && (ld_hit || mem_req_ready_i);
  assign ld_acc     = ld_try && (ld_hit || ld_gnt);

  assign st_ready_o = !q_full;
  assign q_push     = st_valid_i && !q_full;
  assign q_pop      = st_gnt;

  assign mem_req_valid_o = (owner != PORT_IDLE);
  assign mem_req_we_o    = (owner == PORT_STORE);
  assign mem_req_addr_o  = (owner == PORT_LOAD) ? ld_addr_i : head_addr;
  assign mem_req_wdata_o = head_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_busy_q   <= 1'b0;
      fwd_valid_q <= 1'b0;
      fwd_data_q  <= '0;
    end else begin
      fwd_valid_q <= ld_acc && ld_hit;
      if (ld_acc && ld_hit) fwd_data_q <= hit_data;
      if (ld_acc && !ld_hit)     ld_busy_q <= 1'b1;
      else if (mem_rsp_valid_i)  ld_busy_q <= 1'b0;
    end
  end

  assign ld_rsp_valid_o = fwd_valid_q || (ld_busy_q && mem_rsp_valid_i);
  assign ld_rsp_data_o  = fwd_valid_q ? fwd_data_q : mem_rsp_data_i;
  assign empty_o        = q_empty;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          st_ready_o,
  input logic          ld_valid_i,
  input logic          ld_ready_o,
  input logic [AW-1:0] ld_addr_i,
  input logic          ld_rsp_valid_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_req_we_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          empty_o,
  input logic          ld_hit,
  input logic [CW-1:0] q_cnt
);
  logic wr_fire, st_fire, ld_fire;
  assign wr_fire = mem_req_valid_o && mem_req_ready_i && mem_req_we_o;
  assign st_fire = st_valid_i && st_ready_o;
  assign ld_fire = ld_valid_i && ld_ready_o;

  always_comb begin
    if (rst_ni) a_r2_cnt_bound: assert (q_cnt <= CW'(DEPTH));
  end

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_fire && !wr_fire |=> q_cnt == CW'($past(q_cnt) + 1'b1));

  a_r3_drain_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && !st_fire |=> q_cnt == CW'($past(q_cnt) - 1'b1));

  a_r4_miss_owns_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire && !ld_hit |-> mem_req_valid_o && !mem_req_we_o && mem_req_addr_o == ld_addr_i);

  a_r5_hit_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire && ld_hit |-> !(mem_req_valid_o && !mem_req_we_o));

  a_r5_hit_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire && ld_hit |=> ld_rsp_valid_o);

  a_r7_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fire && !ld_hit |=> !ld_ready_o);

  a_r9_empty_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !(mem_req_valid_o && mem_req_we_o));
endmodule

bind sb_top sb_checker #(.AW(AW), .DEPTH(DEPTH)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .st_valid_i      (st_valid_i),
  .st_ready_o      (st_ready_o),
  .ld_valid_i      (ld_valid_i),
  .ld_ready_o      (ld_ready_o),
  .ld_addr_i       (ld_addr_i),
  .ld_rsp_valid_o  (ld_rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .empty_o         (empty_o),
  .ld_hit          (ld_hit),
  .q_cnt           (q_cnt)
);

// File: tb/sb_top_tb_top.sv
module sb_top_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic st_valid_i = 1'b0, st_ready_o;
  logic [AW-1:0] st_addr_i = '0;
  logic [DW-1:0] st_data_i = '0;
  logic ld_valid_i = 1'b0, ld_ready_o;
  logic [AW-1:0] ld_addr_i = '0;
  logic ld_rsp_valid_o;
  logic [DW-1:0] ld_rsp_data_o;
  logic mem_req_valid_o, mem_req_we_o;
  logic mem_req_ready_i = 1'b0;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic mem_rsp_valid_i;
  logic [DW-1:0] mem_rsp_data_i;
  logic empty_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  sb_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  // memory model: unwritten word a reads as 32'hA000_0000 | a
  logic [DW-1:0] mem_word [256];
  logic          mem_set  [256];
  logic          rd_pend;
  logic [DW-1:0] rd_dat;
  int            rd_n, wr_n, op_n;
  logic [AW-1:0] wr_log [1024];
  logic          op_we  [1024];

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return mem_set[a[7:0]] ? mem_word[a[7:0]] : (32'hA000_0000 | 32'(a));
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem_set[i] = 1'b0;
      rd_pend <= 1'b0; rd_dat <= '0;
      mem_rsp_valid_i <= 1'b0; mem_rsp_data_i <= '0;
      rd_n = 0; wr_n = 0; op_n = 0;
    end else begin
      mem_rsp_valid_i <= 1'b0;
      if (rd_pend) begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_data_i  <= rd_dat;
        rd_pend         <= 1'b0;
      end
      if (mem_req_valid_o && mem_req_ready_i) begin
        op_we[op_n] = mem_req_we_o;
        op_n++;
        if (mem_req_we_o) begin
          mem_word[mem_req_addr_o[7:0]] = mem_req_wdata_o;
          mem_set[mem_req_addr_o[7:0]]  = 1'b1;
          wr_log[wr_n] = mem_req_addr_o;
          wr_n++;
        end else begin
          rd_dat  <= mem_val(mem_req_addr_o);
          rd_pend <= 1'b1;
          rd_n++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    st_valid_i = 1'b1; st_addr_i = a; st_data_i = d;
    #1;
    while (!st_ready_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i);
    @(negedge clk_i);
    st_valid_i = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input bit exp_hit, input string req);
    int rb;
    bit got;
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_addr_i = a;
    #1;
    while (!ld_ready_o) begin @(negedge clk_i); #1; end
    rb = rd_n;
    @(posedge clk_i);
    @(negedge clk_i);
    ld_valid_i = 1'b0;
    if (exp_hit) begin
      chk(ld_rsp_valid_o === 1'b1, req, "forward one cycle after accept", 32'(ld_rsp_valid_o), 1);
      chk(ld_rsp_data_o === exp, req, "forwarded data", ld_rsp_data_o, exp);
      chk(rd_n == rb, req, "no memory read on hit", 32'(rd_n - rb), 0);
    end else begin
      got = 1'b0;
      for (int i = 0; i < 20 && !got; i++) begin
        if (ld_rsp_valid_o) got = 1'b1;
        else @(negedge clk_i);
      end
      chk(got, req, "miss response arrives", 32'(got), 1);
      chk(ld_rsp_data_o === exp, req, "memory data", ld_rsp_data_o, exp);
      chk(rd_n == rb + 1, req, "one memory read on miss", 32'(rd_n - rb), 1);
    end
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 100 && !empty_o; i++) @(negedge clk_i);
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk_i);
    chk(empty_o === 1'b1, "R1", "empty after reset", 32'(empty_o), 1);
    chk(st_ready_o === 1'b1, "R1", "store ready after reset", 32'(st_ready_o), 1);
    chk(mem_req_valid_o === 1'b0, "R1", "no memory request", 32'(mem_req_valid_o), 0);
    chk(ld_rsp_valid_o === 1'b0, "R1", "no load response", 32'(ld_rsp_valid_o), 0);
  endtask

  // R5, R6: duplicates held back by a stalled port
  task automatic t_forward_youngest();
    mem_req_ready_i = 1'b0;
    do_store(16'h10, 32'h1111);
    do_store(16'h11, 32'h2222);
    do_store(16'h10, 32'h3333);
    chk(empty_o === 1'b0, "R9", "not empty with stores", 32'(empty_o), 0);
    do_load(16'h10, 32'h3333, 1'b1, "R6");
    do_load(16'h11, 32'h2222, 1'b1, "R5");
    @(negedge clk_i); mem_req_ready_i = 1'b1;
    wait_empty();
    chk(empty_o === 1'b1, "R9", "empty after drain", 32'(empty_o), 1);
    do_load(16'h10, 32'h3333, 1'b0, "R3");
  endtask

  // R4, R3: read overtakes older writes, then writes drain in order
  task automatic t_load_priority();
    int ob, wb;
    mem_req_ready_i = 1'b0;
    for (int i = 0; i < 3; i++) do_store(16'h30 + 16'(i), 32'h300 + 32'(i));
    ob = op_n; wb = wr_n;
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_addr_i = 16'h40; mem_req_ready_i = 1'b1;
    #1;
    chk(mem_req_valid_o && !mem_req_we_o, "R4", "read on port over write",
        {mem_req_valid_o, mem_req_we_o}, 32'b10);
    chk(ld_ready_o === 1'b1, "R4", "miss accepted with port ready", 32'(ld_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i); ld_valid_i = 1'b0;
    for (int i = 0; i < 10 && !ld_rsp_valid_o; i++) @(negedge clk_i);
    chk(ld_rsp_data_o === 32'hA000_0040, "R7", "miss data", ld_rsp_data_o, 32'hA000_0040);
    wait_empty();
    chk(op_we[ob] === 1'b0, "R4", "first port op is the read", 32'(op_we[ob]), 0);
    for (int i = 0; i < 3; i++)
      chk(wr_log[wb + i] == 16'h30 + 16'(i), "R3", "drain order",
          32'(wr_log[wb + i]), 32'h30 + 32'(i));
  endtask

  // R2, R9: fill to DEPTH, backpressure, forward while full
  task automatic t_full();
    int wb;
    mem_req_ready_i = 1'b0;
    wb = wr_n;
    for (int i = 0; i < DEPTH; i++) do_store(16'h60 + 16'(i), 32'h600 + 32'(i));
    @(negedge clk_i);
    st_valid_i = 1'b1; st_addr_i = 16'h70; st_data_i = 32'h7;
    #1;
    chk(st_ready_o === 1'b0, "R2", "backpressure when full", 32'(st_ready_o), 0);
    @(negedge clk_i); st_valid_i = 1'b0;
    do_load(16'h63, 32'h603, 1'b1, "R5");
    @(negedge clk_i);
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    chk(st_ready_o === 1'b1, "R2", "ready after one drain", 32'(st_ready_o), 1);
    wait_empty();
    for (int i = 0; i < DEPTH; i++)
      chk(wr_log[wb + i] == 16'h60 + 16'(i), "R3", "full drain order",
          32'(wr_log[wb + i]), 32'h60 + 32'(i));
    chk(wr_n == wb + DEPTH, "R2", "rejected store never written", 32'(wr_n - wb), DEPTH);
    do_load(16'h67, 32'h607, 1'b0, "R3");
  endtask

  // R8: store and load to one address in one cycle
  task automatic t_same_cycle();
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    st_valid_i = 1'b1; st_addr_i = 16'h50; st_data_i = 32'h6666;
    ld_valid_i = 1'b1; ld_addr_i = 16'h50;
    #1;
    chk(mem_req_valid_o && !mem_req_we_o, "R8", "load misses same-cycle store",
        {mem_req_valid_o, mem_req_we_o}, 32'b10);
    @(posedge clk_i);
    @(negedge clk_i); st_valid_i = 1'b0; ld_valid_i = 1'b0;
    for (int i = 0; i < 10 && !ld_rsp_valid_o; i++) @(negedge clk_i);
    chk(ld_rsp_data_o === 32'hA000_0050, "R8", "old value returned", ld_rsp_data_o, 32'hA000_0050);
    wait_empty();
    do_load(16'h50, 32'h6666, 1'b0, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_forward_youngest();
    t_load_priority();
    t_full();
    t_same_cycle();
    repeat (3) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule